// File: doc/BRIEF.md
# Multicycle Eight-Bit Register CPU

This block is a small processor that runs a fixed seven-instruction set out of one memory shared by program and data. It has a control section and a datapath. The control section holds the program counter, a two-byte instruction register and a state machine. The datapath holds sixteen 8-bit registers and an adder/subtractor. Every instruction is two bytes long. The first byte carries the opcode in bits 7:4 and the register index Rn in bits 3:0. The second byte carries one of four things: a direct address, an immediate value, a signed PC-relative offset, or a second register index Rm in bits 7:4.

The block talks to a synchronous single-port memory of 256 bytes. Read data comes back one clock after the address is presented. A write happens on the clock edge at which the write enable is high. Instruction fetch and data access share this one port, so they take separate cycles. Any opcode from 7 to 15 stops the processor. While stopped it raises a halt flag and freezes the program counter, which stays visible on a debug output.

Top module: `tcpu_top`

## Requirements
- R1: After reset, `dbg_pc` is 0, `halted` is 0 and `mem_we` is 0, and all sixteen registers hold 0. A store of a register that was never written puts 0 into memory.
- R2: Opcode 0x0 (`0000`) loads Rn from the memory byte at the direct address held in the second byte.
- R3: Opcode 0x1 writes Rn to the memory byte at the direct address held in the second byte.
- R4: Opcode 0x2 writes Rm to the memory byte whose address is held in Rn. Rm is taken from bits 7:4 of the second byte.
- R5: Opcode 0x3 loads the second byte into Rn as an immediate.
- R6: Opcode 0x4 sets Rn to (Rn + Rm) mod 256. Rm is taken from bits 7:4 of the second byte.
- R7: Opcode 0x5 sets Rn to (Rn - Rm) mod 256. Rm is taken from bits 7:4 of the second byte.
- R8: Opcode 0x6 jumps when Rn is 0. The new PC is the address of the next instruction plus the second byte read as a two's-complement byte offset, taken mod 256. When Rn is not 0, execution goes on with the next instruction.
- R9: Opcodes 0x7 to 0xF halt the processor. `halted` goes to 1 and stays there. `dbg_pc` freezes at the address that follows the halting instruction. No later instruction runs and no memory write occurs.
- R10: Instructions run in program order, each one taking 4 clocks, except a direct load, which takes 5. The processor fetches the first byte at PC and the second at PC+1, then adds 2 to PC. From release of reset, `halted` rises on the 13th clock edge for the program immediate, direct load, halt.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on the rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| mem_addr | output | 8 | Memory address for fetch, load or store |
| mem_wdata | output | 8 | Data to be written to memory |
| mem_we | output | 1 | Memory write enable |
| mem_rdata | input | 8 | Memory read data, valid one clock after its address |
| halted | output | 1 | High once a halt opcode has executed |
| dbg_pc | output | 8 | Current program counter |

## Verification
The bench sweeps add and subtract over a grid of operand pairs that crosses the carry and borrow wrap. A datapath without modular wrap, or one with its operands swapped, would store the wrong byte. The conditional jump is tested both taken and not taken, and the countdown loop jumps backwards with a negative offset. An offset applied to the wrong base address, or sign-handled wrongly, would skip or repeat instructions and the loop would not total 55. All nine halt opcodes are swept, each followed by a store. A halt that failed to freeze would overwrite the guard byte or move the PC. The indirect store and the exact cycle count catch a misplaced Rm field and a fetch or write-back that takes one state too many or too few.

// File: rtl/tcpu_pkg.sv
package tcpu_pkg;

    // Controller states
    typedef enum logic [2:0] {
        S_FHI  = 3'd0,
        S_FLO  = 3'd1,
        S_DEC  = 3'd2,
        S_EXE  = 3'd3,
        S_WB   = 3'd4,
        S_HALT = 3'd5
    } state_e;

    // Opcodes (bits 7:4 of the first instruction byte)
    localparam logic [3:0] OP_LDD = 4'h0;
    localparam logic [3:0] OP_STD = 4'h1;
    localparam logic [3:0] OP_STI = 4'h2;
    localparam logic [3:0] OP_LDI = 4'h3;
    localparam logic [3:0] OP_ADD = 4'h4;
    localparam logic [3:0] OP_SUB = 4'h5;
    localparam logic [3:0] OP_JZ  = 4'h6;

endpackage

// File: rtl/tcpu_regfile.sv
module tcpu_regfile #(
    parameter int DATA_W = 8,
    parameter int IDX_W  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [IDX_W-1:0]  waddr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [IDX_W-1:0]  ra_idx,
    input  logic [IDX_W-1:0]  rb_idx,
    output logic [DATA_W-1:0] ra_val,
    output logic [DATA_W-1:0] rb_val
);
    localparam int NREG = 1 << IDX_W;

    logic [DATA_W-1:0] regs_q [NREG];
    logic [DATA_W-1:0] regs_d [NREG];

    always_comb begin
        for (int i = 0; i < NREG; i++) regs_d[i] = regs_q[i];
        if (we) regs_d[waddr] = wdata;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < NREG; i++) regs_q[i] <= '0;
        end else begin
            for (int i = 0; i < NREG; i++) regs_q[i] <= regs_d[i];
        end
    end

    assign ra_val = regs_q[ra_idx];
    assign rb_val = regs_q[rb_idx];

    // A write must be readable on the next cycle (R5 / R6 / R7 write-back)
    p_write_visible_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (we && ra_idx == waddr) |=> (ra_val == $past(wdata)) || (ra_idx != $past(waddr)));

endmodule

// File: rtl/tcpu_alu.sv
module tcpu_alu #(
    parameter int DATA_W = 8
) (
    input  logic              sub,
    input  logic [DATA_W-1:0] a,
    input  logic [DATA_W-1:0] b,
    output logic [DATA_W-1:0] res
);
    logic [DATA_W-1:0] b_eff;
    logic              cin;

    always_comb begin
        b_eff = sub ? ~b : b;
        cin   = sub;
        res   = a + b_eff + DATA_W'(cin);
    end

    // Inverse checks: sub result plus b gives a; add result minus b gives a
    always_comb begin
        if (sub) begin
            a_sub_inverse_r7: assert (DATA_W'(res + b) == a);
        end else begin
            a_add_inverse_r6: assert (DATA_W'(res - b) == a);
        end
    end

endmodule

// File: rtl/tcpu_ctrl.sv
module tcpu_ctrl
    import tcpu_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int IDX_W  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DATA_W-1:0] mem_rdata,
    input  logic [DATA_W-1:0] rn_val,
    input  logic [DATA_W-1:0] rm_val,
    input  logic [DATA_W-1:0] alu_res,
    output logic [DATA_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    output logic              mem_we,
    output logic              rf_we,
    output logic [DATA_W-1:0] rf_wdata,
    output logic [IDX_W-1:0]  rn_idx,
    output logic [IDX_W-1:0]  rm_idx,
    output logic              alu_sub,
    output logic [DATA_W-1:0] pc,
    output logic              halted
);
    localparam int OP_W    = DATA_W - IDX_W;
    localparam int INSTR_B = 2;

    typedef struct packed {
        state_e            st;
        logic [DATA_W-1:0] pc;
        logic [DATA_W-1:0] ir_hi;
        logic [DATA_W-1:0] ir_lo;
        logic              halted;
    } ctrl_t;

    ctrl_t cur_q, nxt_d;

    logic [OP_W-1:0] opcode;
    assign opcode = cur_q.ir_hi[DATA_W-1 -: OP_W];
    assign rn_idx = cur_q.ir_hi[IDX_W-1:0];
    assign rm_idx = cur_q.ir_lo[DATA_W-1 -: IDX_W];
    assign alu_sub = (opcode == OP_SUB);

    always_comb begin
        nxt_d     = cur_q;
        mem_addr  = cur_q.pc;
        mem_wdata = rm_val;
        mem_we    = 1'b0;
        rf_we     = 1'b0;
        rf_wdata  = alu_res;
        unique case (cur_q.st)
            S_FHI: begin
                nxt_d.st = S_FLO;
            end
            S_FLO: begin
                mem_addr    = cur_q.pc + DATA_W'(1);
                nxt_d.ir_hi = mem_rdata;
                nxt_d.st    = S_DEC;
            end
            S_DEC: begin
                nxt_d.ir_lo = mem_rdata;
                nxt_d.pc    = cur_q.pc + DATA_W'(INSTR_B);
                nxt_d.st    = S_EXE;
            end
            S_EXE: begin
                nxt_d.st = S_FHI;
                case (opcode)
                    OP_LDD: begin
                        mem_addr = cur_q.ir_lo;
                        nxt_d.st = S_WB;
                    end
                    OP_STD: begin
                        mem_addr  = cur_q.ir_lo;
                        mem_wdata = rn_val;
                        mem_we    = 1'b1;
                    end
                    OP_STI: begin
                        mem_addr  = rn_val;
                        mem_wdata = rm_val;
                        mem_we    = 1'b1;
                    end
                    OP_LDI: begin
                        rf_we    = 1'b1;
                        rf_wdata = cur_q.ir_lo;
                    end
                    OP_ADD, OP_SUB: begin
                        rf_we = 1'b1;
                    end
                    OP_JZ: begin
                        if (rn_val == '0) nxt_d.pc = cur_q.pc + cur_q.ir_lo;
                    end
                    default: begin
                        nxt_d.halted = 1'b1;
                        nxt_d.st     = S_HALT;
                    end
                endcase
            end
            S_WB: begin
                rf_we    = 1'b1;
                rf_wdata = mem_rdata;
                nxt_d.st = S_FHI;
            end
            default: begin
                nxt_d.st = S_HALT;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cur_q <= '{st: S_FHI, pc: '0, ir_hi: '0, ir_lo: '0, halted: 1'b0};
        end else begin
            cur_q <= nxt_d;
        end
    end

    assign pc     = cur_q.pc;
    assign halted = cur_q.halted;

    // Halt is permanent and freezes the program counter
    p_halt_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
        halted |=> halted);
    p_halt_pc_frozen_r9: assert property (@(posedge clk) disable iff (!rst_n)
        halted |=> $stable(pc));
    p_halt_no_write_r9: assert property (@(posedge clk) disable iff (!rst_n)
        halted |-> !mem_we);
    // PC steps by one instruction after the second fetch byte
    p_pc_step_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (cur_q.st == S_DEC) |=> (pc == $past(pc) + DATA_W'(INSTR_B)));
    // A direct load always spends one extra write-back cycle
    p_load_wb_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (cur_q.st == S_EXE && opcode == OP_LDD) |=> (cur_q.st == S_WB));
    // Memory writes only happen in the execute step
    p_we_exec_r3: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |=> (cur_q.st == S_FHI));

endmodule

// File: rtl/tcpu_top.sv
module tcpu_top #(
    parameter int DATA_W = 8,
    parameter int IDX_W  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    output logic [DATA_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    output logic              mem_we,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic              halted,
    output logic [DATA_W-1:0] dbg_pc
);
    logic              rf_we;
    logic [DATA_W-1:0] rf_wdata;
    logic [IDX_W-1:0]  rn_idx;
    logic [IDX_W-1:0]  rm_idx;
    logic [DATA_W-1:0] rn_val;
    logic [DATA_W-1:0] rm_val;
    logic [DATA_W-1:0] alu_res;
    logic              alu_sub;

    tcpu_ctrl #(.DATA_W(DATA_W), .IDX_W(IDX_W)) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .mem_rdata (mem_rdata),
        .rn_val    (rn_val),
        .rm_val    (rm_val),
        .alu_res   (alu_res),
        .mem_addr  (mem_addr),
        .mem_wdata (mem_wdata),
        .mem_we    (mem_we),
        .rf_we     (rf_we),
        .rf_wdata  (rf_wdata),
        .rn_idx    (rn_idx),
        .rm_idx    (rm_idx),
        .alu_sub   (alu_sub),
        .pc        (dbg_pc),
        .halted    (halted)
    );

    tcpu_regfile #(.DATA_W(DATA_W), .IDX_W(IDX_W)) u_rf (
        .clk    (clk),
        .rst_n  (rst_n),
        .we     (rf_we),
        .waddr  (rn_idx),
        .wdata  (rf_wdata),
        .ra_idx (rn_idx),
        .rb_idx (rm_idx),
        .ra_val (rn_val),
        .rb_val (rm_val)
    );

    tcpu_alu #(.DATA_W(DATA_W)) u_alu (
        .sub (alu_sub),
        .a   (rn_val),
        .b   (rm_val),
        .res (alu_res)
    );

endmodule

// File: tb/tb_tcpu_top.sv
module tb_tcpu_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] mem_addr, mem_wdata, mem_rdata, dbg_pc;
    logic       mem_we, halted;

    logic [7:0] mem [256];
    logic       tb_we = 1'b0;
    logic [7:0] tb_a = '0, tb_d = '0;

    int checks = 0;
    int errors = 0;
    int cyc = 0;

    always #10 clk = ~clk;

    tcpu_top dut (
        .clk(clk), .rst_n(rst_n), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_we(mem_we), .mem_rdata(mem_rdata), .halted(halted), .dbg_pc(dbg_pc)
    );

    // Synchronous single-port memory, one-cycle read latency
    always @(posedge clk) begin
        if (tb_we) mem[tb_a] <= tb_d;
        else if (mem_we) mem[mem_addr] <= mem_wdata;
        mem_rdata <= mem[mem_addr];
    end

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 150000) begin
            errors = errors + 1;
            checks = checks + 1;
            $display("FAIL watchdog: actual hung expected finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    task automatic chk(input string req, input int act, input int exp);
        checks = checks + 1;
        if (act != exp) begin
            errors = errors + 1;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic poke(input int a, input int d);
        tb_a = 8'(a); tb_d = 8'(d); tb_we = 1'b1;
        @(posedge clk); #1;
        tb_we = 1'b0;
    endtask

    task automatic ins(input int a, input int b0, input int b1);
        poke(a, b0);
        poke(a + 1, b1);
    endtask

    task automatic hold_reset();
        @(negedge clk);
        rst_n = 1'b0;
        for (int i = 0; i < 256; i++) poke(i, 0);
    endtask

    // Release reset and return edges until halted (limit on failure)
    task automatic run(output int edges);
        @(negedge clk);
        rst_n = 1'b1;
        edges = 0;
        while (!halted && edges < 2000) begin
            @(posedge clk);
            edges++;
            @(negedge clk);
        end
        if (!halted) chk("run_halts", 0, 1);
    endtask

    int n;

    initial begin
        // R1: reset state
        hold_reset();
        @(negedge clk);
        chk("R1 pc", dbg_pc, 0);
        chk("R1 halted", halted, 0);
        chk("R1 we", mem_we, 0);

        // R10: cycle count imm(4) + load(5) + halt(4) = 13 edges
        hold_reset();
        ins(0, 8'h30, 8'h01);
        ins(2, 8'h00, 8'h96);
        ins(4, 8'hF0, 8'h00);
        run(n);
        chk("R10 cycles", n, 13);
        chk("R9 pc after halt", dbg_pc, 6);

        // Countdown sum 10..1 with backward always-taken jump (R8)
        hold_reset();
        ins(0,  8'h30, 8'h00);
        ins(2,  8'h31, 8'h0A);
        ins(4,  8'h32, 8'h01);
        ins(6,  8'h33, 8'h00);
        ins(8,  8'h61, 8'h06);
        ins(10, 8'h40, 8'h10);
        ins(12, 8'h51, 8'h20);
        ins(14, 8'h63, 8'hF8);
        ins(16, 8'h10, 8'hC8);
        ins(18, 8'hF0, 8'h00);
        run(n);
        chk("R8 loop sum", mem[200], 55);
        chk("R8 loop pc", dbg_pc, 20);

        // R2 / R3 / R4 / R1: direct load, direct store, indirect store, zero reg
        for (int x = 3; x < 256; x += 84) begin
            hold_reset();
            poke(150, x);
            ins(0,  8'h05, 8'h96);
            ins(2,  8'h15, 8'h97);
            ins(4,  8'h34, 8'hA0);
            ins(6,  8'h24, 8'h50);
            ins(8,  8'h17, 8'h98);
            poke(152, 8'hEE);
            ins(10, 8'hF0, 8'h00);
            run(n);
            chk("R2/R3 load-store", mem[151], x);
            chk("R4 indirect", mem[160], x);
            chk("R1 reg zero", mem[152], 0);
        end

        // R6 / R7 / R5: add and subtract sweep
        for (int a = 0; a < 256; a += 17) begin
            for (int b = 0; b < 256; b += 23) begin
                hold_reset();
                ins(0,  8'h31, a);
                ins(2,  8'h32, b);
                ins(4,  8'h41, 8'h20);
                ins(6,  8'h11, 8'h64);
                ins(8,  8'h33, a);
                ins(10, 8'h53, 8'h20);
                ins(12, 8'h13, 8'h65);
                ins(14, 8'h12, 8'h66);
                ins(16, 8'hF0, 8'h00);
                run(n);
                chk("R6 add", mem[100], (a + b) % 256);
                chk("R7 sub", mem[101], (a - b + 256) % 256);
                chk("R5 imm", mem[102], b);
            end
        end

        // R8: jump not taken, then taken forward
        for (int t = 0; t < 2; t++) begin
            hold_reset();
            poke(110, 8'h11);
            ins(0, 8'h31, (t == 1) ? 0 : 5);
            ins(2, 8'h61, 8'h04);
            ins(4, 8'h32, 8'hAA);
            ins(6, 8'h12, 8'h6E);
            ins(8, 8'hF0, 8'h00);
            run(n);
            chk(t == 1 ? "R8 taken" : "R8 not taken", mem[110], (t == 1) ? 8'h11 : 8'hAA);
        end

        // R9: every halt opcode freezes PC and blocks later writes
        for (int op = 7; op < 16; op++) begin
            hold_reset();
            poke(111, 8'h33);
            ins(0, op * 16, 8'h00);
            ins(2, 8'h10, 8'h6F);
            run(n);
            repeat (20) @(negedge clk);
            chk("R9 halted", halted, 1);
            chk("R9 pc frozen", dbg_pc, 2);
            chk("R9 no write", mem[111], 8'h33);
        end

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule